// File: doc/BRIEF.md
# Interrupt Status Register with Read-Clear

This block keeps a byte of sticky interrupt flags and a byte of enable bits, and drives one active-low interrupt request line. Other blocks of the chip pulse the event inputs for one cycle, and each pulse sets its matching flag. A separate serial front end raises two one-cycle strobes. The first marks the end of the command byte that selects a read of the status register with clear. The second marks the end of the data byte that carries the status out.

When the command strobe arrives, the block takes a snapshot of the flags and presents it for shifting. It clears the flags and holds the request line inactive until the data strobe. Events that arrive during this window go into a pending byte. At the data strobe the pending byte is merged back into the flags, so no event is lost. If a merged event is enabled, the request line falls again at once. The serial shifter and the address decoding sit outside the block.

Top module: `irq_status_ctl`

## Requirements
- R1: An event pulse outside the read window sets its status flag on the next clock edge, whatever the value of the matching enable bit.
- R2: Outside the read window, irq_n_o is low exactly when some status flag and its enable bit are both 1. Otherwise it is high.
- R3: A write strobe loads the enable byte on the next edge, and the new mask acts on irq_n_o in the following cycle. This applies to flags that were already set.
- R4: A command strobe accepted outside the window copies the status byte onto rd_byte_o, clears every status flag and opens the read window.
- R5: While the read window is open, which is from the accepted command strobe until the data strobe, irq_n_o is high.
- R6: An event that arrives during the window, in the same cycle as the accepted command strobe, or in the same cycle as the data strobe is set in status once the window closes. If that flag is enabled, irq_n_o goes low right after the window.
- R7: A data strobe outside the window has no effect on status. A command strobe inside the window does not change rd_byte_o and does not reopen the window.
- R8: After reset the enable byte is 0x00, irq_n_o is high, rd_byte_o is 0x00, and status is 0x40: bit 6 is the power-up flag and the only flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | One-cycle event pulses, one per flag |
| en_wr_i | input | 1 | Enable-byte write strobe |
| en_data_i | input | 8 | New enable byte |
| cmd_done_i | input | 1 | Command byte of a read-with-clear has completed |
| data_done_i | input | 1 | Status data byte has been fully shifted out |
| rd_byte_o | output | 8 | Status snapshot for the shifter |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The hardest situations to reach from the ports are events that coincide exactly with one of the two strobes. An event can land on the command strobe, where it must miss the snapshot but survive. An event can land on the data strobe, where it must be merged. The bench schedules event pulses in the same cycle as each strobe. It then runs a second read to bring the resulting status out through rd_byte_o. It also drives an enabled event in the middle of the window, checks that the line stays high, and checks that the line falls right after the data strobe.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int FLAG_W = 8;
  typedef logic [FLAG_W-1:0] flag_vec_t;

  // Request is active when any flag meets its enable bit.
  function automatic logic req_active(input flag_vec_t flags, input flag_vec_t mask);
    return |(flags & mask);
  endfunction

  // Value of status when the read window closes.
  function automatic flag_vec_t merge_back(input flag_vec_t held, input flag_vec_t fresh);
    return held | fresh;
  endfunction
endpackage

// File: rtl/irq_read_window.sv
module irq_read_window (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_done_i,
  input  logic data_done_i,
  output logic busy_o,
  output logic acc_cmd_o,
  output logic acc_data_o
);
  logic busy_q;

  // A command strobe only counts while idle; a data strobe only while busy.
  assign acc_cmd_o  = cmd_done_i & ~busy_q;
  assign acc_data_o = data_done_i & busy_q;
  assign busy_o     = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          busy_q <= 1'b0;
    else if (acc_cmd_o)  busy_q <= 1'b1;
    else if (acc_data_o) busy_q <= 1'b0;
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_status_pkg::*;
#(
  parameter int PWRUP_BIT = 6
) (
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t evt_i,
  input  logic      busy_i,
  input  logic      take_i,
  input  logic      merge_i,
  output flag_vec_t status_o,
  output flag_vec_t pend_o,
  output flag_vec_t snap_o
);
  flag_vec_t merged;
  assign merged = merge_back(pend_o, evt_i);

  for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
    localparam logic RST_VAL = (i == PWRUP_BIT);
    logic st_q, pd_q, sn_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q <= RST_VAL;
        pd_q <= 1'b0;
        sn_q <= 1'b0;
      end else if (take_i) begin
        sn_q <= st_q;
        st_q <= 1'b0;
        pd_q <= evt_i[i];
      end else if (merge_i) begin
        st_q <= merged[i];
        pd_q <= 1'b0;
      end else if (busy_i) begin
        pd_q <= pd_q | evt_i[i];
      end else begin
        st_q <= st_q | evt_i[i];
      end
    end

    assign status_o[i] = st_q;
    assign pend_o[i]   = pd_q;
    assign snap_o[i]   = sn_q;
  end
endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen
  import irq_status_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en_wr_i,
  input  flag_vec_t en_data_i,
  input  flag_vec_t status_i,
  input  logic      busy_i,
  output flag_vec_t enable_o,
  output logic      irq_n_o
);
  flag_vec_t en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (en_wr_i) en_q <= en_data_i;
  end

  assign enable_o = en_q;
  assign irq_n_o  = busy_i | ~req_active(status_i, en_q);
endmodule

// File: rtl/irq_status_ctl.sv
module irq_status_ctl
  import irq_status_pkg::*;
#(
  parameter int PWRUP_BIT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FLAG_W-1:0] evt_i,
  input  logic             en_wr_i,
  input  logic [FLAG_W-1:0] en_data_i,
  input  logic             cmd_done_i,
  input  logic             data_done_i,
  output logic [FLAG_W-1:0] rd_byte_o,
  output logic             irq_n_o
);
  logic      busy, acc_cmd, acc_data;
  flag_vec_t status_q, pend_q, enable_q;

  irq_read_window i_win (
    .clk(clk), .rst_n(rst_n),
    .cmd_done_i(cmd_done_i), .data_done_i(data_done_i),
    .busy_o(busy), .acc_cmd_o(acc_cmd), .acc_data_o(acc_data)
  );

  irq_flag_bank #(.PWRUP_BIT(PWRUP_BIT)) i_flags (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .busy_i(busy),
    .take_i(acc_cmd), .merge_i(acc_data),
    .status_o(status_q), .pend_o(pend_q), .snap_o(rd_byte_o)
  );

  irq_line_gen i_line (
    .clk(clk), .rst_n(rst_n), .en_wr_i(en_wr_i), .en_data_i(en_data_i),
    .status_i(status_q), .busy_i(busy), .enable_o(enable_q), .irq_n_o(irq_n_o)
  );
endmodule

// File: rtl/irq_status_ctl_chk.sv
module irq_status_ctl_chk
  import irq_status_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input flag_vec_t evt,
  input logic      busy,
  input logic      acc_cmd,
  input logic      acc_data,
  input flag_vec_t status,
  input flag_vec_t pend,
  input flag_vec_t snap,
  input flag_vec_t enable,
  input logic      irq_n
);
  // R5
  window_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> irq_n);

  // R2
  line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (status & enable) != '0) |-> !irq_n);

  // R4
  snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_cmd |=> (snap == $past(status)) && (status == '0));

  // R1
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !acc_cmd && evt != '0) |=> ((status & $past(evt)) == $past(evt)));

  // R6
  merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_data |=> (status == ($past(pend) | $past(evt))));

  // R7
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !acc_data) |=> $stable(snap));
endmodule

bind irq_status_ctl irq_status_ctl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .evt(evt_i), .busy(busy), .acc_cmd(acc_cmd),
  .acc_data(acc_data), .status(status_q), .pend(pend_q), .snap(rd_byte_o),
  .enable(enable_q), .irq_n(irq_n_o)
);

// File: tb/test_irq_status_ctl.sv
module test_irq_status_ctl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_i = '0;
  logic       en_wr_i = 1'b0;
  logic [7:0] en_data_i = '0;
  logic       cmd_done_i = 1'b0;
  logic       data_done_i = 1'b0;
  logic [7:0] rd_byte_o;
  logic       irq_n_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_ctl i_irq_status_ctl (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .en_wr_i(en_wr_i),
    .en_data_i(en_data_i), .cmd_done_i(cmd_done_i), .data_done_i(data_done_i),
    .rd_byte_o(rd_byte_o), .irq_n_o(irq_n_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // Called at a falling edge: drive for one cycle, return at the next falling edge.
  task automatic drive(input logic [7:0] ev, input logic cmd, input logic dat);
    evt_i = ev; cmd_done_i = cmd; data_done_i = dat;
    @(negedge clk);
    evt_i = '0; cmd_done_i = 1'b0; data_done_i = 1'b0;
  endtask

  task automatic set_mask(input logic [7:0] m);
    en_wr_i = 1'b1; en_data_i = m;
    @(negedge clk);
    en_wr_i = 1'b0;
  endtask

  task automatic read_clear(input string tag, input logic [7:0] exp);
    drive('0, 1'b1, 1'b0);
    chk({tag, " snapshot"}, rd_byte_o, exp);
    chk({tag, " line high in window (R5)"}, {7'd0, irq_n_o}, 8'd1);
    drive('0, 1'b0, 1'b1);
  endtask

  task automatic t_reset;
    chk("R8 line after reset", {7'd0, irq_n_o}, 8'd1);
    chk("R8 snapshot after reset", rd_byte_o, 8'h00);
    read_clear("R8 power-up flag R4", 8'h40);
    read_clear("R4 cleared by read", 8'h00);
  endtask

  task automatic t_masked_flag;
    drive(8'h08, 1'b0, 1'b0);
    chk("R1 masked flag keeps line high", {7'd0, irq_n_o}, 8'd1);
    read_clear("R1 masked flag recorded", 8'h08);
  endtask

  task automatic t_enabled;
    set_mask(8'h20);
    drive(8'h20, 1'b0, 1'b0);
    chk("R2 enabled flag drives line low", {7'd0, irq_n_o}, 8'd0);
    read_clear("R4 enabled read", 8'h20);
    chk("R2 line high after clear", {7'd0, irq_n_o}, 8'd1);
  endtask

  task automatic t_mid_window;
    drive(8'h20, 1'b0, 1'b0);
    drive('0, 1'b1, 1'b0);
    chk("R5 line forced high", {7'd0, irq_n_o}, 8'd1);
    drive(8'h20, 1'b0, 1'b0);
    chk("R5 event in window line stays high", {7'd0, irq_n_o}, 8'd1);
    drive('0, 1'b0, 1'b1);
    chk("R6 line low after window", {7'd0, irq_n_o}, 8'd0);
    read_clear("R6 held event", 8'h20);
    chk("R6 line high after second read", {7'd0, irq_n_o}, 8'd1);
  endtask

  task automatic t_edges;
    drive(8'h04, 1'b0, 1'b0);
    drive(8'h02, 1'b1, 1'b0);
    chk("R6 event on command strobe not in snapshot", rd_byte_o, 8'h04);
    drive(8'h01, 1'b0, 1'b1);
    read_clear("R6 events on both strobes kept", 8'h03);
  endtask

  task automatic t_stray;
    drive(8'h10, 1'b0, 1'b0);
    drive('0, 1'b0, 1'b1);
    read_clear("R7 stray data strobe ignored", 8'h10);
    drive(8'h80, 1'b0, 1'b0);
    drive('0, 1'b1, 1'b0);
    drive(8'h01, 1'b1, 1'b0);
    chk("R7 second command keeps snapshot", rd_byte_o, 8'h80);
    chk("R7 window stays open", {7'd0, irq_n_o}, 8'd1);
    drive('0, 1'b0, 1'b1);
    read_clear("R7 event during ignored command kept", 8'h01);
  endtask

  task automatic t_mask_late;
    set_mask(8'h00);
    drive(8'h40, 1'b0, 1'b0);
    chk("R3 masked line high", {7'd0, irq_n_o}, 8'd1);
    set_mask(8'h40);
    chk("R3 mask on existing flag", {7'd0, irq_n_o}, 8'd0);
    set_mask(8'h00);
    chk("R3 mask removed", {7'd0, irq_n_o}, 8'd1);
    read_clear("R3 flag kept", 8'h40);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_masked_flag();
    t_enabled();
    t_mid_window();
    t_edges();
    t_stray();
    t_mask_late();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule